// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers external interrupt sources for a small 8-bit CPU into one latched request. The main source is a dedicated active-low pin. A static option adds a group of four general-purpose port inputs to it, and these act at the opposite polarity: high or rising is active. The block synchronises every input to the system clock and combines them into one active condition. A qualifying transition on that condition sets a request flag. The CPU sees the flag on a registered request output, gated by an enable bit.

A second static option selects the trigger mode:
- **Edge-only.** Only a transition into the active state sets the flag. The combined input must go back to idle before a new request can be latched.
- **Edge-plus-level.** The request output also stays asserted for as long as any enabled source is active.

The flag is cleared in three ways: by reset, by the CPU's interrupt vector fetch acknowledge, or by software writing 1 to an acknowledge bit. A byte-wide status and control register on a simple address/read/write bus holds these bits. The block also exports the synchronised level of the dedicated pin, so that branch-on-pin instructions can test it.

Top module: `irq_req_ctrl`

## Requirements
- R1: After reset the request output is 0. A read of the control register at address 0x0A returns 0x80: enable bit 7 is 1, flag bit 3 is 0.
- R2: A falling edge on the dedicated pin sets the flag (bit 3 reads 1). With enable set, it also raises the request output.
- R3: In edge-only mode, while the pin stays low after the flag is cleared, the flag does not set again. It sets again only after the pin returns high and then falls again.
- R4: In level mode, the request output stays at 1 while the pin is low, even after the flag is cleared. It returns to 0 once the pin is high and the flag is clear.
- R5: With the port option on, a rising edge on any one of the four port inputs sets the flag. With the option off, port inputs have no effect on the flag or on the request output.
- R6: In level mode with the port option on, a high level on a port input holds the request output at 1 after the flag is cleared.
- R7: Bit 7 of the control register is the enable. The flag sets regardless of it, but the request output is 0 whenever the enable is 0.
- R8: The flag is cleared by a vector fetch acknowledge, or by a register write with bit 1 set. A write with bit 1 clear leaves the flag unchanged.
- R9: Bits 6:4 and 2:0 of the control register always read 0, bit 1 included. A read of any other address returns 0.
- R10: If a qualifying edge is detected in the same cycle as a clear, the flag ends up set.
- R11: The exported pin level follows the dedicated pin two clock edges after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n_pin | input | 1 | Dedicated active-low interrupt pin (asynchronous) |
| port_pin | input | 4 | Optional active-high port interrupt inputs (asynchronous) |
| opt_level | input | 1 | Static option: 1 selects edge-plus-level triggering |
| opt_port_en | input | 1 | Static option: 1 adds the port inputs as sources |
| bus_addr | input | 8 | Register bus address |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the read strobe |
| vec_fetch | input | 1 | Interrupt vector fetch acknowledge from the CPU |
| irq_out | output | 1 | Registered interrupt request to the CPU |
| pin_level | output | 1 | Synchronised level of the dedicated pin |

## Verification
Two events can fall in the same cycle: a new edge being detected and a clear of the flag by vector fetch. The bench arranges this by counting clock edges through the synchroniser. It first leaves the flag set with the pin idle. It then drives a falling edge and raises the vector fetch exactly in the cycle when the edge is detected. The result is judged on the flag and on the request output one edge later: both must still be 1. A sweep over all 256 write values also crosses the enable and acknowledge bits against a set flag.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h0A;
  localparam int EN_BIT   = 7;
  localparam int FLAG_BIT = 3;
  localparam int ACK_BIT  = 1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("irq_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{IDLE}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_trigger.sv
module irq_trigger #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_s,
  input  logic [NPORT-1:0] port_s,
  input  logic             port_en,
  output logic             active,
  output logic             edge_pulse
);
  logic [NPORT-1:0] port_act;
  logic             prev_q;

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_port
      assign port_act[g] = port_en & port_s[g];
    end
  endgenerate

  assign active     = ~pin_s | (|port_act);
  assign edge_pulse = active & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= active;
  end
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              vec_fetch,
  input  logic              edge_pulse,
  output logic              irqe_q,
  output logic              flag_q,
  output logic              flag_nxt,
  output logic [DATA_W-1:0] rdata
);
  logic hit, ack, clr;
  logic [DATA_W-1:0] rd_val;

  assign hit      = (addr == CTRL_ADDR);
  assign ack      = wr & hit & wdata[ACK_BIT];
  assign clr      = vec_fetch | ack;
  assign flag_nxt = edge_pulse | (flag_q & ~clr);

  always_comb begin
    rd_val           = '0;
    rd_val[EN_BIT]   = irqe_q;
    rd_val[FLAG_BIT] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqe_q <= 1'b1;
      flag_q <= 1'b0;
      rdata  <= '0;
    end else begin
      flag_q <= flag_nxt;
      if (wr && hit) irqe_q <= wdata[EN_BIT];
      rdata <= (rd && hit) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl
  import irq_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_n_pin,
  input  logic [NPORT-1:0]  port_pin,
  input  logic              opt_level,
  input  logic              opt_port_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              vec_fetch,
  output logic              irq_out,
  output logic              pin_level
);
  localparam int SYNC_W = NPORT + 1;
  localparam logic [SYNC_W-1:0] SYNC_IDLE = {{NPORT{1'b0}}, 1'b1};

  logic [SYNC_W-1:0] sync_q;
  logic active, edge_pulse, irqe_q, flag_q, flag_nxt;

  irq_sync #(.W(SYNC_W), .STAGES(STAGES), .IDLE(SYNC_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d({port_pin, irq_n_pin}), .q(sync_q)
  );

  irq_trigger #(.NPORT(NPORT)) u_trig (
    .clk(clk), .rst(rst), .pin_s(sync_q[0]), .port_s(sync_q[SYNC_W-1:1]),
    .port_en(opt_port_en), .active(active), .edge_pulse(edge_pulse)
  );

  irq_regif u_reg (
    .clk(clk), .rst(rst), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .wdata(bus_wdata), .vec_fetch(vec_fetch), .edge_pulse(edge_pulse),
    .irqe_q(irqe_q), .flag_q(flag_q), .flag_nxt(flag_nxt), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= irqe_q & (flag_nxt | (opt_level & active));
  end

  assign pin_level = sync_q[0];
endmodule

// File: rtl/irq_req_ctrl_chk.sv
module irq_req_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq_out,
  input logic [7:0] bus_rdata,
  input logic       vec_fetch,
  input logic       edge_pulse,
  input logic       flag_q,
  input logic       irqe_q
);
  a_r1_reset_state: assert property (@(posedge clk) rst |=> (irqe_q && !flag_q && !irq_out));
  a_r7_mask: assert property (@(posedge clk) disable iff (rst) !irqe_q |=> !irq_out);
  a_r8_vec_clear: assert property (@(posedge clk) disable iff (rst)
    (vec_fetch && !edge_pulse) |=> !flag_q);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst) edge_pulse |=> flag_q);
  a_r9_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[6:4] == 3'b000) && (bus_rdata[2:0] == 3'b000));
  a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (edge_pulse && irqe_q) |=> irq_out);
endmodule

bind irq_req_ctrl irq_req_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .irq_out(irq_out), .bus_rdata(bus_rdata),
  .vec_fetch(vec_fetch), .edge_pulse(edge_pulse), .flag_q(flag_q), .irqe_q(irqe_q)
);

// File: tb/tb_irq_req_ctrl.sv
module tb_irq_req_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A = 8'h0A;

  logic clk = 0, rst = 1;
  logic irq_n_pin = 1;
  logic [3:0] port_pin = 0;
  logic opt_level = 0, opt_port_en = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_rd = 0, bus_wr = 0, vec_fetch = 0;
  logic irq_out, pin_level;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_req_ctrl dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); v = bus_rdata; bus_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic pulse_pin();
    @(negedge clk); irq_n_pin = 0; cyc(4);
    irq_n_pin = 1; cyc(4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3); rst = 0; cyc(1);
    // R1 reset state
    check("R1 irq_out", irq_out, 0);
    rd(A, rv); check("R1 reg", rv, 8'h80);

    // R11 pin level delay
    @(negedge clk); irq_n_pin = 0;
    cyc(1); check("R11 one edge", pin_level, 1);
    cyc(1); check("R11 two edges", pin_level, 0);
    // R2 falling edge sets flag
    cyc(2); check("R2 irq_out", irq_out, 1);
    rd(A, rv); check("R2 flag", rv, 8'h88);
    // R3 held low, cleared, no retrigger
    wr(A, 8'h82); cyc(5);
    rd(A, rv); check("R3 no retrigger", rv, 8'h80);
    check("R3 irq_out low", irq_out, 0);
    irq_n_pin = 1; cyc(4);
    rd(A, rv); check("R3 still clear", rv, 8'h80);
    @(negedge clk); irq_n_pin = 0; cyc(4);
    rd(A, rv); check("R3 rearmed", rv, 8'h88);
    irq_n_pin = 1; cyc(4);

    // R8 write 0 to ack bit keeps flag, vec fetch clears
    wr(A, 8'h80); rd(A, rv); check("R8 ack0 no effect", rv, 8'h88);
    @(negedge clk); vec_fetch = 1; @(negedge clk); vec_fetch = 0;
    rd(A, rv); check("R8 vec clears", rv, 8'h80);
    check("R8 irq_out", irq_out, 0);

    // R9 other address
    pulse_pin();
    rd(8'h0B, rv); check("R9 other addr", rv, 8'h00);

    // R10 edge coincident with clear: flag set, pin idle
    rd(A, rv); check("R10 pre", rv, 8'h88);
    @(negedge clk); irq_n_pin = 0;
    @(negedge clk);
    @(negedge clk); vec_fetch = 1;
    @(negedge clk); vec_fetch = 0;
    check("R10 irq_out", irq_out, 1);
    rd(A, rv); check("R10 set wins", rv, 8'h88);
    irq_n_pin = 1; cyc(4); wr(A, 8'h82);

    // R7 mask
    wr(A, 8'h00); pulse_pin();
    check("R7 masked", irq_out, 0);
    rd(A, rv); check("R7 flag sets", rv, 8'h08);
    wr(A, 8'h82); cyc(1);

    // R4 level mode
    opt_level = 1;
    @(negedge clk); irq_n_pin = 0; cyc(4);
    wr(A, 8'h82); cyc(2);
    check("R4 level holds", irq_out, 1);
    rd(A, rv); check("R4 flag clear", rv, 8'h80);
    irq_n_pin = 1; cyc(5);
    check("R4 released", irq_out, 0);
    opt_level = 0;

    // R5 port sweep
    for (int en = 0; en < 2; en++) begin
      opt_port_en = en[0];
      for (int b = 0; b < 4; b++) begin
        wr(A, 8'h82);
        @(negedge clk); port_pin = 4'(1 << b); cyc(4);
        check($sformatf("R5 irq_out en=%0d bit=%0d", en, b), irq_out, en[0]);
        rd(A, rv); check($sformatf("R5 flag en=%0d bit=%0d", en, b), rv, en[0] ? 8'h88 : 8'h80);
        port_pin = 0; cyc(4);
      end
    end

    // R6 port level
    opt_level = 1; wr(A, 8'h82);
    @(negedge clk); port_pin = 4'b0100; cyc(4);
    wr(A, 8'h82); cyc(2);
    check("R6 port level holds", irq_out, 1);
    port_pin = 0; cyc(5);
    check("R6 released", irq_out, 0);
    opt_level = 0; opt_port_en = 0;

    // R8/R9/R7 sweep of all write values with flag set
    for (int v = 0; v < 256; v++) begin
      wr(A, 8'h82); pulse_pin();
      wr(A, 8'(v));
      rd(A, rv);
      check($sformatf("R9 R8 sweep v=%02h", v), rv, {v[7], 3'b000, ~v[1], 3'b000});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule